// File: doc/BRIEF.md
# Two-Level Public Key Chain Authentication Checker

This block decides whether a boot image may be trusted. It keeps two 384-bit reference hashes for primary public keys. Each slot is programmed once and then locked, and each has a revoke flag of its own. It also keeps a 32-entry revocation map for secondary keys. The hash engine and the signature verifier are outside the block. For each boot attempt, the block receives their results: a freshly computed hash of the supplied primary key, the identifier of the secondary key, and two signature-valid flags.

A pulse on `start` samples all check inputs. The checker then walks three steps in a fixed order. First it checks the primary key (revocation, then hash equality). Next it checks the secondary key (revocation, then signature). Last it checks the image signature. The first failing step stops the walk in a terminal fail state with a reason code. If every step passes, it ends in a terminal pass state. Only the session reset `rst_n` returns it to idle. Stored hashes, lock flags and revoke flags behave like one-time-programmable storage: they survive `rst_n` and are cleared only by `por_n`, which stands for a blank device.

Top module: `key_chain_auth`

## Requirements
- R1: A primary slot (index 0 or 1) takes the value on `prog_hash` on the first `prog_en` write after `por_n` and is locked from then on; any later write to a locked slot is ignored and the stored hash stays unchanged.
- R2: `pri_rev_en` sets the revoke flag of slot `pri_rev_slot`; the flag is sticky, survives `rst_n`, and a check through a revoked slot always fails with code 2, even when the hash matches and even when it does not.
- R3: A non-revoked primary slot passes only when `key_hash` equals the stored value in all 384 bits and the slot has been programmed; a single differing bit (bit 0 or bit 383) or an unprogrammed slot fails with code 1.
- R4: `sec_rev_en` sets a sticky revoke flag for secondary identifier `sec_rev_id` when that identifier is below 32, and writes with identifiers of 32 or above are ignored. A check whose `sec_id` is revoked, or is 32 or above, fails with code 3, and this takes priority over a bad secondary signature.
- R5: A non-revoked secondary key with `sec_sig_ok` low fails with code 4.
- R6: When the primary and secondary steps pass and `img_sig_ok` is low, the check fails with code 5.
- R7: Result codes are 0 pass, 1 primary mismatch, 2 primary revoked, 3 secondary revoked, 4 secondary signature bad, 5 image signature bad. Inputs are sampled at the rising edge where `start` is high in idle, called edge k. A primary failure shows `done`/`fail` after edge k+1, a secondary failure after k+2, and an image result or a pass after k+3. `pass` and `fail` are never high together, and `busy` is high in between.
- R8: The result holds, and `start` is ignored, until `rst_n`; `rst_n` returns the block to idle with `busy`, `done`, `pass` and `fail` low and `code` 0, and leaves stored hashes, locks and revoke flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Session reset, active low, asynchronous assert, synchronous release |
| por_n | input | 1 | Power-on clear of key storage (blank device), active low |
| prog_en | input | 1 | Program request for a primary hash slot |
| prog_slot | input | 1 | Slot index to program |
| prog_hash | input | 384 | Hash value to program |
| pri_rev_en | input | 1 | Revoke request for a primary slot |
| pri_rev_slot | input | 1 | Primary slot to revoke |
| sec_rev_en | input | 1 | Revoke request for a secondary key |
| sec_rev_id | input | 8 | Secondary identifier to revoke |
| start | input | 1 | Begin a chain check (sampled in idle) |
| sel_slot | input | 1 | Primary slot to check against |
| key_hash | input | 384 | Computed hash of the supplied primary key |
| sec_id | input | 8 | Identifier of the secondary key |
| sec_sig_ok | input | 1 | Secondary key signature verified |
| img_sig_ok | input | 1 | Image signature verified |
| busy | output | 1 | Check in progress |
| done | output | 1 | Terminal state reached |
| pass | output | 1 | Chain accepted |
| fail | output | 1 | Chain rejected |
| code | output | 3 | Reason code |

## Verification
A lost lock or a cleared revoke flag shows up at the ports only on the next check through that slot or identifier. It appears as a pass or a code-1 result where a code 2 or the old hash's pass was due, so the bench re-checks after every write and after every session reset. A step out of order, or a wrong capture, shows as a wrong code or a `done` edge one cycle early or late. The bench therefore checks each outcome's latency counted in edges from the sampling edge. A truncated identifier compare appears when a revoke of identifier 40 is followed by a pass on identifier 8.

// File: rtl/key_chain_pkg.sv
package key_chain_pkg;

  typedef enum logic [2:0] {
    RC_PASS         = 3'd0,
    RC_PRI_MISMATCH = 3'd1,
    RC_PRI_REVOKED  = 3'd2,
    RC_SEC_REVOKED  = 3'd3,
    RC_SEC_SIG_BAD  = 3'd4,
    RC_IMG_SIG_BAD  = 3'd5
  } res_code_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRI  = 3'd1,
    ST_SEC  = 3'd2,
    ST_IMG  = 3'd3,
    ST_PASS = 3'd4,
    ST_FAIL = 3'd5
  } chain_state_e;

endpackage

// File: rtl/kc_rst_sync.sv
module kc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pri_hash_store.sv
module pri_hash_store #(
  parameter int HASH_W  = 384,
  parameter int NUM_PRI = 2,
  parameter int SLOT_W  = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              prog_en,
  input  logic [SLOT_W-1:0] prog_slot,
  input  logic [HASH_W-1:0] prog_hash,
  input  logic              rev_en,
  input  logic [SLOT_W-1:0] rev_slot,
  input  logic [SLOT_W-1:0] sel_slot,
  input  logic [HASH_W-1:0] cmp_hash,
  output logic              match_o,
  output logic              revoked_o,
  output logic [NUM_PRI-1:0] lock_o,
  output logic [NUM_PRI-1:0] rev_o
);

  logic [NUM_PRI-1:0] slot_eq;

  for (genvar i = 0; i < NUM_PRI; i++) begin : g_slot
    logic [HASH_W-1:0] hash_q;
    logic              lock_q;
    logic              rev_q;
    logic              wr_en;
    logic              rv_en;

    // A slot accepts exactly one write; the lock closes it for good.
    assign wr_en = prog_en && (prog_slot == SLOT_W'(i)) && !lock_q;
    assign rv_en = rev_en && (rev_slot == SLOT_W'(i));

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        hash_q <= '0;
        lock_q <= 1'b0;
      end else if (wr_en) begin
        hash_q <= prog_hash;
        lock_q <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     rev_q <= 1'b0;
      else if (rv_en) rev_q <= 1'b1;
    end

    assign slot_eq[i] = lock_q && (hash_q == cmp_hash);
    assign lock_o[i]  = lock_q;
    assign rev_o[i]   = rev_q;
  end

  always_comb begin
    if (int'(sel_slot) < NUM_PRI) begin
      match_o   = slot_eq[sel_slot];
      revoked_o = rev_o[sel_slot];
    end else begin
      match_o   = 1'b0;
      revoked_o = 1'b1;
    end
  end

endmodule

// File: rtl/sec_revoke_map.sv
module sec_revoke_map #(
  parameter int NUM_SEC  = 32,
  parameter int SEC_ID_W = 8
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rev_en,
  input  logic [SEC_ID_W-1:0] rev_id,
  input  logic [SEC_ID_W-1:0] chk_id,
  output logic                revoked_o,
  output logic [NUM_SEC-1:0]  map_o
);

  localparam int IDX_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1;

  for (genvar i = 0; i < NUM_SEC; i++) begin : g_ent
    logic ent_q;
    logic hit;

    // Full-width compare: identifiers beyond the map never alias an entry.
    assign hit = rev_en && (rev_id == SEC_ID_W'(i));

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)   ent_q <= 1'b0;
      else if (hit) ent_q <= 1'b1;
    end

    assign map_o[i] = ent_q;
  end

  logic in_range;
  assign in_range  = (chk_id < SEC_ID_W'(NUM_SEC));
  assign revoked_o = !in_range || map_o[chk_id[IDX_W-1:0]];

endmodule

// File: rtl/chain_fsm.sv
module chain_fsm
  import key_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pri_match,
  input  logic       pri_revoked,
  input  logic       sec_revoked,
  input  logic       sec_sig_ok,
  input  logic       img_sig_ok,
  output logic       busy,
  output logic       done,
  output logic       pass,
  output logic       fail,
  output logic [2:0] code
);

  chain_state_e state_q, state_d;
  res_code_e    code_q, code_d;
  logic         cap_en;
  logic         pri_match_q, pri_rev_q, sec_rev_q, sec_ok_q, img_ok_q;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    cap_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          state_d = ST_PRI;
        end
      end
      ST_PRI: begin
        if (pri_rev_q) begin
          state_d = ST_FAIL;
          code_d  = RC_PRI_REVOKED;
        end else if (!pri_match_q) begin
          state_d = ST_FAIL;
          code_d  = RC_PRI_MISMATCH;
        end else begin
          state_d = ST_SEC;
        end
      end
      ST_SEC: begin
        if (sec_rev_q) begin
          state_d = ST_FAIL;
          code_d  = RC_SEC_REVOKED;
        end else if (!sec_ok_q) begin
          state_d = ST_FAIL;
          code_d  = RC_SEC_SIG_BAD;
        end else begin
          state_d = ST_IMG;
        end
      end
      ST_IMG: begin
        if (!img_ok_q) begin
          state_d = ST_FAIL;
          code_d  = RC_IMG_SIG_BAD;
        end else begin
          state_d = ST_PASS;
          code_d  = RC_PASS;
        end
      end
      default: begin
        state_d = state_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= RC_PASS;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_match_q <= 1'b0;
      pri_rev_q   <= 1'b0;
      sec_rev_q   <= 1'b0;
      sec_ok_q    <= 1'b0;
      img_ok_q    <= 1'b0;
    end else if (cap_en) begin
      pri_match_q <= pri_match;
      pri_rev_q   <= pri_revoked;
      sec_rev_q   <= sec_revoked;
      sec_ok_q    <= sec_sig_ok;
      img_ok_q    <= img_sig_ok;
    end
  end

  assign busy = (state_q == ST_PRI) || (state_q == ST_SEC) || (state_q == ST_IMG);
  assign pass = (state_q == ST_PASS);
  assign fail = (state_q == ST_FAIL);
  assign done = pass || fail;
  assign code = code_q;

endmodule

// File: rtl/key_chain_auth.sv
module key_chain_auth #(
  parameter int HASH_W   = 384,
  parameter int NUM_PRI  = 2,
  parameter int NUM_SEC  = 32,
  parameter int SEC_ID_W = 8,
  localparam int SLOT_W  = (NUM_PRI > 1) ? $clog2(NUM_PRI) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_n,
  input  logic                prog_en,
  input  logic [SLOT_W-1:0]   prog_slot,
  input  logic [HASH_W-1:0]   prog_hash,
  input  logic                pri_rev_en,
  input  logic [SLOT_W-1:0]   pri_rev_slot,
  input  logic                sec_rev_en,
  input  logic [SEC_ID_W-1:0] sec_rev_id,
  input  logic                start,
  input  logic [SLOT_W-1:0]   sel_slot,
  input  logic [HASH_W-1:0]   key_hash,
  input  logic [SEC_ID_W-1:0] sec_id,
  input  logic                sec_sig_ok,
  input  logic                img_sig_ok,
  output logic                busy,
  output logic                done,
  output logic                pass,
  output logic                fail,
  output logic [2:0]          code
);

  logic               ses_rst_n;
  logic               sto_rst_n;
  logic               pri_match;
  logic               pri_revoked;
  logic               sec_revoked;
  logic [NUM_PRI-1:0] pri_lock;
  logic [NUM_PRI-1:0] pri_rev;
  logic [NUM_SEC-1:0] sec_map;

  kc_rst_sync u_ses_sync (.clk(clk), .arst_n(rst_n), .srst_n(ses_rst_n));
  kc_rst_sync u_sto_sync (.clk(clk), .arst_n(por_n), .srst_n(sto_rst_n));

  pri_hash_store #(
    .HASH_W (HASH_W),
    .NUM_PRI(NUM_PRI),
    .SLOT_W (SLOT_W)
  ) u_store (
    .clk      (clk),
    .por_n    (sto_rst_n),
    .prog_en  (prog_en),
    .prog_slot(prog_slot),
    .prog_hash(prog_hash),
    .rev_en   (pri_rev_en),
    .rev_slot (pri_rev_slot),
    .sel_slot (sel_slot),
    .cmp_hash (key_hash),
    .match_o  (pri_match),
    .revoked_o(pri_revoked),
    .lock_o   (pri_lock),
    .rev_o    (pri_rev)
  );

  sec_revoke_map #(
    .NUM_SEC (NUM_SEC),
    .SEC_ID_W(SEC_ID_W)
  ) u_secmap (
    .clk      (clk),
    .por_n    (sto_rst_n),
    .rev_en   (sec_rev_en),
    .rev_id   (sec_rev_id),
    .chk_id   (sec_id),
    .revoked_o(sec_revoked),
    .map_o    (sec_map)
  );

  chain_fsm u_fsm (
    .clk        (clk),
    .rst_n      (ses_rst_n),
    .start      (start),
    .pri_match  (pri_match),
    .pri_revoked(pri_revoked),
    .sec_revoked(sec_revoked),
    .sec_sig_ok (sec_sig_ok),
    .img_sig_ok (img_sig_ok),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fail       (fail),
    .code       (code)
  );

endmodule

// File: rtl/key_chain_auth_chk.sv
module key_chain_auth_chk #(
  parameter int NUM_PRI = 2,
  parameter int NUM_SEC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               por_n,
  input logic [NUM_PRI-1:0] pri_lock,
  input logic [NUM_PRI-1:0] pri_rev,
  input logic [NUM_SEC-1:0] sec_map,
  input logic               busy,
  input logic               done,
  input logic               pass,
  input logic               fail,
  input logic [2:0]         code
);

  for (genvar i = 0; i < NUM_PRI; i++) begin : g_pri
    // R1: a locked slot stays locked
    p_lock_sticky_r1: assert property (@(posedge clk) disable iff (!por_n)
      pri_lock[i] |=> pri_lock[i]);
    // R2: a revoked primary slot stays revoked, session reset included
    p_rev_sticky_r2: assert property (@(posedge clk) disable iff (!por_n)
      pri_rev[i] |=> pri_rev[i]);
  end

  for (genvar j = 0; j < NUM_SEC; j++) begin : g_sec
    // R4: secondary revoke entries never clear
    p_sec_sticky_r4: assert property (@(posedge clk) disable iff (!por_n)
      sec_map[j] |=> sec_map[j]);
  end

  // R7: pass carries code 0 and excludes fail
  p_pass_clean_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    pass |-> (code == 3'd0) && !fail);

  // R7: a failure always carries a reason code in range
  p_fail_code_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    fail |-> (code != 3'd0) && (code <= 3'd5));

  // R7: a terminal state is only reached through the busy steps
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(done) |-> $past(busy));

  // R8: the result holds until session reset
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    done |=> done && $stable(code) && $stable(pass));

  // R7: busy and done are exclusive
  p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(busy && done));

endmodule

bind key_chain_auth key_chain_auth_chk #(
  .NUM_PRI(NUM_PRI),
  .NUM_SEC(NUM_SEC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .por_n   (por_n),
  .pri_lock(pri_lock),
  .pri_rev (pri_rev),
  .sec_map (sec_map),
  .busy    (busy),
  .done    (done),
  .pass    (pass),
  .fail    (fail),
  .code    (code)
);

// File: tb/tb_key_chain_auth.sv
`timescale 1ns/1ps
module tb_key_chain_auth;

  localparam int HW = 384;

  logic          clk = 1'b0;
  logic          rst_n, por_n;
  logic          prog_en, prog_slot;
  logic [HW-1:0] prog_hash;
  logic          pri_rev_en, pri_rev_slot;
  logic          sec_rev_en;
  logic [7:0]    sec_rev_id;
  logic          start, sel_slot;
  logic [HW-1:0] key_hash;
  logic [7:0]    sec_id;
  logic          sec_sig_ok, img_sig_ok;
  logic          busy, done, pass, fail;
  logic [2:0]    code;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  key_chain_auth dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .prog_en(prog_en), .prog_slot(prog_slot), .prog_hash(prog_hash),
    .pri_rev_en(pri_rev_en), .pri_rev_slot(pri_rev_slot),
    .sec_rev_en(sec_rev_en), .sec_rev_id(sec_rev_id),
    .start(start), .sel_slot(sel_slot), .key_hash(key_hash),
    .sec_id(sec_id), .sec_sig_ok(sec_sig_ok), .img_sig_ok(img_sig_ok),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .code(code)
  );

  function automatic logic [HW-1:0] mk_hash(input int seed);
    logic [HW-1:0] h;
    for (int w = 0; w < HW / 32; w++)
      h[w*32 +: 32] = 32'(seed * 32'h9E3779B1) ^ 32'(w * 32'h01000193);
    return h;
  endfunction

  logic [HW-1:0] H0, H1, H2;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic session_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic program_slot(input logic s, input logic [HW-1:0] h);
    @(negedge clk);
    prog_en = 1'b1; prog_slot = s; prog_hash = h;
    @(negedge clk);
    prog_en = 1'b0;
  endtask

  // Runs one chain check; checks code, pass/fail and latency in edges after edge k.
  task automatic run_chain(input string req, input logic s, input logic [HW-1:0] h,
                           input int id, input logic sok, input logic iok,
                           input int exp_code, input int exp_lat);
    int lat;
    @(negedge clk);
    start = 1'b1; sel_slot = s; key_hash = h; sec_id = 8'(id);
    sec_sig_ok = sok; img_sig_ok = iok;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(req, "latency", lat, exp_lat);
    check(req, "code", int'(code), exp_code);
    check(req, "pass", int'(pass), exp_code == 0 ? 1 : 0);
    check(req, "fail", int'(fail), exp_code != 0 ? 1 : 0);
    session_reset();
  endtask

  task automatic t_reset_state();
    check("R8", "busy", int'(busy), 0);
    check("R8", "done", int'(done), 0);
    check("R8", "pass", int'(pass), 0);
    check("R8", "code", int'(code), 0);
  endtask

  task automatic t_unprogrammed();
    run_chain("R3", 1'b0, '0, 1, 1'b1, 1'b1, 1, 1);
  endtask

  task automatic t_pass_and_mismatch();
    run_chain("R7", 1'b0, H0, 5, 1'b1, 1'b1, 0, 3);
    run_chain("R7", 1'b1, H1, 31, 1'b1, 1'b1, 0, 3);
    run_chain("R3", 1'b0, H0 ^ {1'b1, {(HW-1){1'b0}}}, 5, 1'b1, 1'b1, 1, 1);
    run_chain("R3", 1'b0, H0 ^ {{(HW-1){1'b0}}, 1'b1}, 5, 1'b1, 1'b1, 1, 1);
    run_chain("R3", 1'b1, H0, 5, 1'b1, 1'b1, 1, 1);
  endtask

  task automatic t_write_protect();
    program_slot(1'b0, H2);
    run_chain("R1", 1'b0, H0, 2, 1'b1, 1'b1, 0, 3);
    run_chain("R1", 1'b0, H2, 2, 1'b1, 1'b1, 1, 1);
  endtask

  task automatic t_sig_failures();
    run_chain("R5", 1'b0, H0, 3, 1'b0, 1'b1, 4, 2);
    run_chain("R6", 1'b0, H0, 3, 1'b1, 1'b0, 5, 3);
  endtask

  task automatic t_sec_revoke();
    @(negedge clk);
    sec_rev_en = 1'b1; sec_rev_id = 8'd5;
    @(negedge clk);
    sec_rev_id = 8'd40;
    @(negedge clk);
    sec_rev_en = 1'b0;
    run_chain("R4", 1'b0, H0, 5, 1'b1, 1'b1, 3, 2);
    run_chain("R4", 1'b0, H0, 5, 1'b0, 1'b1, 3, 2);
    run_chain("R4", 1'b0, H0, 32, 1'b1, 1'b1, 3, 2);
    run_chain("R4", 1'b0, H0, 8, 1'b1, 1'b1, 0, 3);
    run_chain("R4", 1'b0, H0, 4, 1'b1, 1'b1, 0, 3);
  endtask

  task automatic t_pri_revoke();
    @(negedge clk);
    pri_rev_en = 1'b1; pri_rev_slot = 1'b1;
    @(negedge clk);
    pri_rev_en = 1'b0;
    run_chain("R2", 1'b1, H1, 6, 1'b1, 1'b1, 2, 1);
    run_chain("R2", 1'b1, H2, 6, 1'b1, 1'b1, 2, 1);
    run_chain("R2", 1'b0, H0, 6, 1'b1, 1'b1, 0, 3);
    session_reset();
    run_chain("R8", 1'b1, H1, 6, 1'b1, 1'b1, 2, 1);
    run_chain("R8", 1'b0, H0, 5, 1'b1, 1'b1, 3, 2);
  endtask

  task automatic t_start_ignored();
    @(negedge clk);
    start = 1'b1; sel_slot = 1'b0; key_hash = H0; sec_id = 8'd6;
    sec_sig_ok = 1'b0; img_sig_ok = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R8", "code before restart", int'(code), 4);
    start = 1'b1; sec_sig_ok = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b0;
    check("R8", "code held", int'(code), 4);
    check("R8", "fail held", int'(fail), 1);
    session_reset();
    t_reset_state();
  endtask

  initial begin
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    H0 = mk_hash(11); H1 = mk_hash(23); H2 = mk_hash(37);
    rst_n = 1'b0; por_n = 1'b0;
    prog_en = 1'b0; prog_slot = 1'b0; prog_hash = '0;
    pri_rev_en = 1'b0; pri_rev_slot = 1'b0;
    sec_rev_en = 1'b0; sec_rev_id = '0;
    start = 1'b0; sel_slot = 1'b0; key_hash = '0; sec_id = '0;
    sec_sig_ok = 1'b0; img_sig_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (3) @(negedge clk);

    t_reset_state();
    t_unprogrammed();
    program_slot(1'b0, H0);
    program_slot(1'b1, H1);
    t_pass_and_mismatch();
    t_write_protect();
    t_sig_failures();
    t_sec_revoke();
    t_pri_revoke();
    t_start_ignored();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule